// File: doc/BRIEF.md
# Shared Second-Level Cache Region Maintenance Engine

This block performs software-requested maintenance on a shared second-level cache. It keeps a direct-mapped model of the cache state: a tag, a valid bit and a dirty bit for every set. On request it walks a range of line addresses, or every set, and flushes the matching lines, invalidates them, or does both. Each dirty line that has to leave the cache is sent out on a valid/ready write-back port. The engine holds no data storage.

Software reaches the engine through four word registers, selected by `reg_addr`. Address 0 is control, 1 is region end, 2 is region start and 3 is the whole-cache trigger. Software first programs the control word and the region end. Writing the region start then launches the walk. The control word carries the operation code, a mode bit that decides whether an invalidate writes dirty lines back first, a read-only busy flag, a sticky error flag and a disable bit. A line install port and a combinational probe port load and observe the tag model.

Top module: `l2_rgn_maint`

## Requirements
- R1: After reset the control word (address 0) reads 0: operation 000, mode 0, busy 0, error 0, disable 0. `wb_valid` is low and every line probes as a miss.
- R2: The line is 128 bytes when `LSZ_CODE` is 0 and 64 bytes otherwise (default 64). Set index = address bits just above the line offset, `SETS` sets (default 16). Tag = remaining upper bits. Offset bits of start, end, install and probe addresses are ignored. Write-back addresses are line aligned.
- R3: A write to address 2 while idle launches a walk over line addresses from floor(start) through floor(end), where end is the value last written to address 1. Only lines whose stored tag matches the walked address change. If floor(end) is below floor(start), only the start line is processed.
- R4: Busy (control bit 2) reads 1 from the cycle after the launching write until the last line is processed. Each line takes one cycle unless it waits on `wb_ready`, so an N-line walk with `wb_ready` held high keeps busy set for N cycles.
- R5: Operation code 000 in control bits [11:9] is flush. Each dirty matching line is written back and stays valid and clean. Clean lines emit nothing.
- R6: Operation code 001 with mode (control bit 1) clear invalidates each matching line without write-back, even a dirty one.
- R7: Operation code 001 with mode set writes back dirty matching lines and invalidates all matching lines. Any operation code other than 001 behaves as flush.
- R8: Writing a word with bit 0 set to address 3 while idle walks all sets in index order, `SETS` cycles with `wb_ready` high. It invalidates every valid line and first writes back the dirty ones only when mode is set.
- R9: Each owed write-back is presented once, in walk order. `wb_valid` and `wb_addr` hold steady until `wb_ready` is sampled high.
- R10: A region launch or whole-cache trigger written while busy is ignored and sets the error flag (control bit 3). The flag clears only when software writes control with bit 3 set.
- R11: A line install (`ins_en`) is ignored while disable (control bit 0) is set or while busy. Otherwise it loads tag, valid and the given dirty value into the addressed set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 end, 2 start, 3 whole-cache trigger |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data for `reg_addr` |
| ins_en | input | 1 | Install a line into the tag model |
| ins_addr | input | ADDR_W | Address of the installed line |
| ins_dirty | input | 1 | Dirty value of the installed line |
| probe_addr | input | ADDR_W | Address looked up by the probe |
| probe_hit | output | 1 | Probe address is valid in the model |
| probe_dirty | output | 1 | Probed line is valid and dirty |
| wb_valid | output | 1 | A write-back is offered |
| wb_ready | input | 1 | Receiver accepts the write-back |
| wb_addr | output | ADDR_W | Line-aligned address of the write-back |

## Verification
The properties assume that software programs the region end before the start. They also assume that `wb_ready` may drop at any time, so the hold property only binds the engine's side of the handshake. The stimulus changes control and end only while the engine is idle. It does send extra launches and installs while busy, to exercise the ignore-and-flag path. During one walk `wb_ready` follows a pseudo-random pattern so that the stall path is covered. Every other walk keeps it high, so the busy duration can be predicted exactly.

// File: rtl/rgnm_pkg.sv
package rgnm_pkg;
  typedef enum logic [1:0] {
    RA_CTRL   = 2'd0,
    RA_END    = 2'd1,
    RA_START  = 2'd2,
    RA_INVALL = 2'd3
  } reg_sel_e;

  localparam int CB_DIS   = 0;
  localparam int CB_MODE  = 1;
  localparam int CB_BUSY  = 2;
  localparam int CB_ERR   = 3;
  localparam int CB_OP_LO = 9;
  localparam logic [2:0] OPC_INV = 3'b001;

  function automatic int line_bytes(input int code);
    return (code == 0) ? 128 : 64;
  endfunction
endpackage

// File: rtl/rgnm_regs.sv
module rgnm_regs
  import rgnm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              busy,
  output logic              launch_rgn,
  output logic              launch_all,
  output logic              op_inv,
  output logic              mode,
  output logic              dis,
  output logic              err,
  output logic [ADDR_W-1:0] end_addr
);
  logic [2:0]        op_q, op_d;
  logic              mode_q, mode_d, dis_q, dis_d, err_q, err_d;
  logic [ADDR_W-1:0] end_q, start_q;
  logic              ctrl_wr, end_wr, start_wr, all_wr, busy_hit;
  logic              ctrl_en, err_en, end_en, start_en;

  assign ctrl_wr  = reg_we && (reg_addr == RA_CTRL);
  assign end_wr   = reg_we && (reg_addr == RA_END) && !busy;
  assign start_wr = reg_we && (reg_addr == RA_START);
  assign all_wr   = reg_we && (reg_addr == RA_INVALL) && reg_wdata[0];
  assign busy_hit = busy && (start_wr || all_wr);

  assign launch_rgn = start_wr && !busy;
  assign launch_all = all_wr && !busy;

  always_comb begin
    op_d   = op_q;
    mode_d = mode_q;
    dis_d  = dis_q;
    err_d  = err_q;
    if (ctrl_wr) begin
      op_d   = reg_wdata[CB_OP_LO +: 3];
      mode_d = reg_wdata[CB_MODE];
      dis_d  = reg_wdata[CB_DIS];
    end
    if (busy_hit) err_d = 1'b1;
    else if (ctrl_wr && reg_wdata[CB_ERR]) err_d = 1'b0;
  end

  assign ctrl_en  = ctrl_wr;
  assign err_en   = busy_hit || ctrl_wr;
  assign end_en   = end_wr;
  assign start_en = launch_rgn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      mode_q  <= 1'b0;
      dis_q   <= 1'b0;
      err_q   <= 1'b0;
      end_q   <= '0;
      start_q <= '0;
    end else begin
      if (ctrl_en) begin
        op_q   <= op_d;
        mode_q <= mode_d;
        dis_q  <= dis_d;
      end
      if (err_en)   err_q   <= err_d;
      if (end_en)   end_q   <= reg_wdata;
      if (start_en) start_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[CB_DIS]        = dis_q;
        reg_rdata[CB_MODE]       = mode_q;
        reg_rdata[CB_BUSY]       = busy;
        reg_rdata[CB_ERR]        = err_q;
        reg_rdata[CB_OP_LO +: 3] = op_q;
      end
      RA_END:   reg_rdata = end_q;
      RA_START: reg_rdata = start_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign op_inv   = (op_q == OPC_INV);
  assign mode     = mode_q;
  assign dis      = dis_q;
  assign err      = err_q;
  assign end_addr = end_q;
endmodule

// File: rtl/rgnm_tags.sv
module rgnm_tags #(
  parameter int SETS = 16,
  parameter int TAGW = 22,
  localparam int IDXW = $clog2(SETS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_en,
  input  logic [IDXW-1:0] ins_idx,
  input  logic [TAGW-1:0] ins_tag,
  input  logic            ins_dirty,
  input  logic            upd_en,
  input  logic            upd_inv,
  input  logic [IDXW-1:0] rd_idx,
  output logic            rd_valid,
  output logic            rd_dirty,
  output logic [TAGW-1:0] rd_tag,
  input  logic [IDXW-1:0] pr_idx,
  output logic            pr_valid,
  output logic            pr_dirty,
  output logic [TAGW-1:0] pr_tag
);
  logic            v_arr [SETS];
  logic            d_arr [SETS];
  logic [TAGW-1:0] t_arr [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_set
    logic            v_q, v_d, d_q, d_d;
    logic [TAGW-1:0] t_q;
    logic            ins_sel, upd_sel;

    assign ins_sel = ins_en && (ins_idx == IDXW'(g));
    assign upd_sel = upd_en && (rd_idx == IDXW'(g));

    always_comb begin
      v_d = v_q;
      d_d = d_q;
      if (ins_sel) begin
        v_d = 1'b1;
        d_d = ins_dirty;
      end else if (upd_sel) begin
        v_d = v_q && !upd_inv;
        d_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        t_q <= '0;
      end else begin
        if (ins_sel || upd_sel) begin
          v_q <= v_d;
          d_q <= d_d;
        end
        if (ins_sel) t_q <= ins_tag;
      end
    end

    assign v_arr[g] = v_q;
    assign d_arr[g] = d_q;
    assign t_arr[g] = t_q;
  end

  assign rd_valid = v_arr[rd_idx];
  assign rd_dirty = d_arr[rd_idx];
  assign rd_tag   = t_arr[rd_idx];
  assign pr_valid = v_arr[pr_idx];
  assign pr_dirty = d_arr[pr_idx];
  assign pr_tag   = t_arr[pr_idx];
endmodule

// File: rtl/rgnm_walk.sv
module rgnm_walk #(
  parameter int ADDR_W = 32,
  parameter int OFF    = 6,
  parameter int SETS   = 16,
  localparam int IDXW  = $clog2(SETS),
  localparam int LW    = ADDR_W - OFF,
  localparam int TAGW  = LW - IDXW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_rgn,
  input  logic              launch_all,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic              op_inv,
  input  logic              mode,
  input  logic              rd_valid,
  input  logic              rd_dirty,
  input  logic [TAGW-1:0]   rd_tag,
  input  logic              wb_ready,
  output logic              busy,
  output logic [IDXW-1:0]   rd_idx,
  output logic              upd_en,
  output logic              upd_inv,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr
);
  logic          busy_q, busy_d, all_q, all_d, inv_q, inv_d, mode_q, mode_d;
  logic [LW-1:0] cur_q, cur_d, last_q, last_d;
  logic          hit, need_wb, step, reg_en;

  assign rd_idx  = cur_q[IDXW-1:0];
  assign hit     = busy_q && rd_valid && (all_q || (rd_tag == cur_q[LW-1:IDXW]));
  assign need_wb = hit && rd_dirty && (inv_q ? mode_q : 1'b1);
  assign step    = busy_q && (!need_wb || wb_ready);

  assign upd_en   = step && hit;
  assign upd_inv  = inv_q;
  assign wb_valid = need_wb;
  assign wb_addr  = {rd_tag, rd_idx, {OFF{1'b0}}};
  assign busy     = busy_q;

  always_comb begin
    busy_d = busy_q;
    all_d  = all_q;
    inv_d  = inv_q;
    mode_d = mode_q;
    cur_d  = cur_q;
    last_d = last_q;
    if (launch_rgn) begin
      busy_d = 1'b1;
      all_d  = 1'b0;
      inv_d  = op_inv;
      mode_d = mode;
      cur_d  = start_addr[ADDR_W-1:OFF];
      last_d = end_addr[ADDR_W-1:OFF];
    end else if (launch_all) begin
      busy_d = 1'b1;
      all_d  = 1'b1;
      inv_d  = 1'b1;
      mode_d = mode;
      cur_d  = '0;
      last_d = LW'(SETS - 1);
    end else if (step) begin
      if (cur_q >= last_q) busy_d = 1'b0;
      else                 cur_d  = cur_q + 1'b1;
    end
  end

  assign reg_en = launch_rgn || launch_all || step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      all_q  <= 1'b0;
      inv_q  <= 1'b0;
      mode_q <= 1'b0;
      cur_q  <= '0;
      last_q <= '0;
    end else if (reg_en) begin
      busy_q <= busy_d;
      all_q  <= all_d;
      inv_q  <= inv_d;
      mode_q <= mode_d;
      cur_q  <= cur_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/l2_rgn_maint.sv
module l2_rgn_maint
  import rgnm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SETS     = 16,
  parameter int LSZ_CODE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              ins_en,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              ins_dirty,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_hit,
  output logic              probe_dirty,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr
);
  localparam int OFF  = $clog2(line_bytes(LSZ_CODE));
  localparam int IDXW = $clog2(SETS);
  localparam int TAGW = ADDR_W - OFF - IDXW;

  logic            rst_m, rst_q;
  logic            busy, launch_rgn, launch_all, op_inv, mode, dis, err;
  logic [ADDR_W-1:0] end_addr;
  logic [IDXW-1:0] rd_idx;
  logic            rd_valid, rd_dirty, upd_en, upd_inv;
  logic [TAGW-1:0] rd_tag, pr_tag;
  logic            pr_valid, pr_dirty, ins_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  rgnm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_q), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .launch_rgn(launch_rgn), .launch_all(launch_all), .op_inv(op_inv),
    .mode(mode), .dis(dis), .err(err), .end_addr(end_addr)
  );

  assign ins_ok = ins_en && !dis && !busy;

  rgnm_tags #(.SETS(SETS), .TAGW(TAGW)) u_tags (
    .clk(clk), .rst_n(rst_q),
    .ins_en(ins_ok), .ins_idx(ins_addr[OFF +: IDXW]),
    .ins_tag(ins_addr[ADDR_W-1:OFF+IDXW]), .ins_dirty(ins_dirty),
    .upd_en(upd_en), .upd_inv(upd_inv),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
    .pr_idx(probe_addr[OFF +: IDXW]), .pr_valid(pr_valid),
    .pr_dirty(pr_dirty), .pr_tag(pr_tag)
  );

  rgnm_walk #(.ADDR_W(ADDR_W), .OFF(OFF), .SETS(SETS)) u_walk (
    .clk(clk), .rst_n(rst_q), .launch_rgn(launch_rgn), .launch_all(launch_all),
    .start_addr(reg_wdata), .end_addr(end_addr), .op_inv(op_inv), .mode(mode),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
    .wb_ready(wb_ready), .busy(busy), .rd_idx(rd_idx), .upd_en(upd_en),
    .upd_inv(upd_inv), .wb_valid(wb_valid), .wb_addr(wb_addr)
  );

  assign probe_hit   = pr_valid && (pr_tag == probe_addr[ADDR_W-1:OFF+IDXW]);
  assign probe_dirty = probe_hit && pr_dirty;
endmodule

// File: rtl/rgnm_checker.sv
module rgnm_checker #(
  parameter int ADDR_W = 32,
  parameter int OFF    = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [1:0]        reg_addr,
  input logic              busy,
  input logic              err,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [ADDR_W-1:0] wb_addr
);
  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr)); // R9

  AST_WB_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> busy); // R4

  AST_LAUNCH_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && (reg_addr == 2'd2) && !busy |=> busy); // R3

  AST_BUSY_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && (reg_addr == 2'd2) && busy |=> err); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err && !(reg_we && (reg_addr == 2'd0)) |=> err); // R10

  AST_WB_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_addr[OFF-1:0] == '0)); // R2
endmodule

bind l2_rgn_maint rgnm_checker #(.ADDR_W(ADDR_W), .OFF(OFF)) u_chk (
  .clk(clk), .rst_n(rst_q), .reg_we(reg_we), .reg_addr(reg_addr),
  .busy(busy), .err(err), .wb_valid(wb_valid), .wb_ready(wb_ready),
  .wb_addr(wb_addr)
);

// File: tb/l2_rgn_maint_test.sv
module l2_rgn_maint_test;
  logic        clk, rst_n, reg_we, ins_en, ins_dirty, wb_ready;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, ins_addr, probe_addr, wb_addr;
  logic        probe_hit, probe_dirty, wb_valid;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit rnd_rdy = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] exp_q[$];

  l2_rgn_maint uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ins_en(ins_en),
    .ins_addr(ins_addr), .ins_dirty(ins_dirty), .probe_addr(probe_addr),
    .probe_hit(probe_hit), .probe_dirty(probe_dirty), .wb_valid(wb_valid),
    .wb_ready(wb_ready), .wb_addr(wb_addr)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, act cycle %0d exp below 150000", cyc);
      summary_and_end();
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wb_ready = rnd_rdy ? lfsr[0] : 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each accepted write-back
  always @(negedge clk) begin
    if (rst_n && wb_valid && wb_ready) begin
      if (exp_q.size() == 0) check(0, "R9 unexpected write-back", wb_addr, 32'hFFFF_FFFF);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(wb_addr == e, "R9 write-back address", wb_addr, e);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic install(input logic [31:0] a, input logic dty);
    @(posedge clk); #1;
    ins_en = 1; ins_addr = a; ins_dirty = dty;
    @(posedge clk); #1;
    ins_en = 0;
  endtask

  task automatic probe(input logic [31:0] a, input logic eh, ed, input string req);
    probe_addr = a;
    @(negedge clk);
    check(probe_hit == eh && probe_dirty == ed, req, {30'd0, probe_hit, probe_dirty}, {30'd0, eh, ed});
  endtask

  task automatic rd_ctrl(output logic [31:0] v);
    reg_addr = 2'd0;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic wait_idle(input int c0, output int dur);
    reg_addr = 2'd0;
    forever begin
      @(negedge clk);
      if (!reg_rdata[2]) break;
    end
    dur = cyc - c0;
    check(exp_q.size() == 0, "R9 all expected write-backs seen", exp_q.size(), 0);
  endtask

  task automatic region(input logic [31:0] s, e, ctl, output int dur);
    int c0;
    wr(2'd0, ctl);
    wr(2'd1, e);
    wr(2'd2, s);
    c0 = cyc;
    wait_idle(c0, dur);
  endtask

  task automatic whole(input logic [31:0] ctl, output int dur);
    int c0;
    wr(2'd0, ctl);
    wr(2'd3, 32'd1);
    c0 = cyc;
    wait_idle(c0, dur);
  endtask

  initial begin
    int d;
    logic [31:0] v;
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    ins_en = 0; ins_addr = 0; ins_dirty = 0; probe_addr = 0; wb_ready = 1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset state
    rd_ctrl(v);
    check(v == 32'd0, "R1 control reads zero after reset", v, 0);
    check(wb_valid == 1'b0, "R1 no write-back after reset", wb_valid, 0);
    probe(32'h0000_1000, 0, 0, "R1 line invalid after reset");

    // R5/R2/R4 flush with unaligned bounds
    install(32'h1000, 1); install(32'h1040, 0);
    install(32'h1080, 1); install(32'h10C0, 1);
    probe(32'h1000, 1, 1, "R11 install loads dirty line");
    exp_q.push_back(32'h1000); exp_q.push_back(32'h1080);
    region(32'h1010, 32'h10BF, 32'h0, d);
    check(d == 3, "R4 busy cycles for 3-line flush", d, 3);
    probe(32'h1000, 1, 0, "R5 flushed line stays valid and clean");
    probe(32'h1040, 1, 0, "R5 clean line untouched");
    probe(32'h10C0, 1, 1, "R3 line past end untouched");
    probe(32'h1023, 1, 0, "R2 probe offset bits ignored");

    // R6 invalidate without write-back; tag mismatch untouched
    region(32'h2040, 32'h207F, 32'h200, d);
    probe(32'h1040, 1, 0, "R3 other tag in walked set untouched");
    region(32'h10C0, 32'h10FF, 32'h200, d);
    check(d == 1, "R4 busy cycles for single line", d, 1);
    probe(32'h10C0, 0, 0, "R6 dirty line dropped without write-back");

    // R7 flush-then-invalidate with write-back stalls
    for (int i = 0; i < 8; i++) install(32'h2000 + i * 64, (i % 2) == 0);
    for (int i = 0; i < 8; i += 2) exp_q.push_back(32'h2000 + i * 64);
    rnd_rdy = 1;
    region(32'h2000, 32'h21FF, 32'h202, d);
    rnd_rdy = 0;
    probe(32'h2000, 0, 0, "R7 dirty line invalidated after write-back");
    probe(32'h2040, 0, 0, "R7 clean line invalidated");

    // R8 whole-cache invalidate, mode set then clear
    install(32'h6000, 1); install(32'h6040, 0); install(32'h63C0, 1);
    exp_q.push_back(32'h6000); exp_q.push_back(32'h63C0);
    whole(32'h2, d);
    check(d == 16, "R8 whole walk takes SETS cycles", d, 16);
    probe(32'h6040, 0, 0, "R8 all lines invalid");
    probe(32'h63C0, 0, 0, "R8 dirty line invalid");
    install(32'h7000, 1);
    whole(32'h0, d);
    probe(32'h7000, 0, 0, "R8 mode clear drops dirty line silently");

    // R10/R11 writes while busy
    begin
      int c0;
      wr(2'd0, 32'h0); wr(2'd1, 32'hFFFF); wr(2'd2, 32'h0);
      c0 = cyc;
      wr(2'd2, 32'h40);
      wr(2'd3, 32'h1);
      install(32'h20000, 1);
      wait_idle(c0, d);
      check(d == 1024, "R10 busy launch ignored, walk length kept", d, 1024);
    end
    rd_ctrl(v);
    check(v[3] == 1'b1, "R10 error flag set by busy launch", v[3], 1);
    probe(32'h20000, 0, 0, "R11 install while busy ignored");
    wr(2'd0, 32'h0);
    rd_ctrl(v);
    check(v[3] == 1'b1, "R10 error flag sticky without clear bit", v[3], 1);
    wr(2'd0, 32'h8);
    rd_ctrl(v);
    check(v[3] == 1'b0, "R10 error flag cleared by write-1", v[3], 0);

    // R11 disable blocks installs
    wr(2'd0, 32'h1);
    install(32'h4000, 1);
    probe(32'h4000, 0, 0, "R11 install while disabled ignored");
    wr(2'd0, 32'h0);
    install(32'h4000, 1);
    probe(32'h4000, 1, 1, "R11 install after re-enable");

    // R7 other operation code behaves as flush
    exp_q.push_back(32'h4000);
    region(32'h4000, 32'h403F, 32'h402, d);
    probe(32'h4000, 1, 0, "R7 op 010 flushes and keeps line");

    // R3 end below start: only start line
    install(32'h3000, 1); install(32'h3040, 1);
    exp_q.push_back(32'h3040);
    region(32'h3040, 32'h303F, 32'h0, d);
    check(d == 1, "R3 end below start walks one line", d, 1);
    probe(32'h3000, 1, 1, "R3 line below start untouched");

    summary_and_end();
  end
endmodule